// File: doc/BRIEF.md
# Cascadable Down-Counting Reload Timer Pair

This block holds two 8-bit down counters. Each one loads a reload value and counts down to zero, and the step after zero brings the reload value back. That step also gives a one-cycle underflow pulse, which a separate interrupt controller can latch. A compare value sets the duty of a pulse-width output whose period is the reload value plus one count.

A mode input joins the two counters into one 16-bit counter. In that mode the low byte borrows into the high byte. Only the underflow of the full 16-bit value reloads the pair and raises a flag.

Each counter chooses its count source. It can count on a prescaled enable supplied from outside the block, or on rising edges of its own external clock pin. The external path is first synchronised to the system clock. It can then pass through a noise rejector that drops pulses shorter than a set number of system clock periods.

Top module: `pair_reload_timer`

## Requirements
- R1: While `rst` is high, `count_o` is 16'hFFFF and both `pwm_o` and `uf_o` are 0. These values hold in the first cycle after reset.
- R2: A pulse on `preset_i[c]` loads the channel's reload byte into its counter at the next clock edge. This happens whether or not the channel runs, and a preset wins over a count step in the same cycle.
- R3: A channel whose `run_i` bit is 0 does not count, whatever its count source does.
- R4: With `src_ext_i[c]` = 0 (internal) a running channel steps once for each cycle `tick_i` is high, and its external pin is ignored. With `src_ext_i[c]` = 1 (external) it steps on rising edges of `ext_clk_i[c]`, and `tick_i` is ignored.
- R5: Each step lowers the count by one. A step taken at zero reloads the counter and pulses `uf_o[c]` high for exactly one cycle, so the period is reload+1 steps.
- R6: While enabled, `pwm_o` is high in the cycle after the count is less than or equal to the compare value, and low in the cycle after the count is above it.
- R7: With `pwm_en_i[c]` = 0, the output `pwm_o[c]` is held low.
- R8: With `cascade_i` = 1, `count_o` is one 16-bit counter. Its low byte is bits 7:0. A low-byte step at zero decrements the high byte, and the low byte wraps to FFh unless the whole value is zero. Channel 0's run, preset, source, filter and output-enable inputs govern the pair. Channel 1's inputs are ignored.
- R9: With `cascade_i` = 1, the output `uf_o[1]` pulses only when the full 16-bit value underflows, and `uf_o[0]` stays 0. The 16-bit compare drives `pwm_o[1]`, and `pwm_o[0]` stays low.
- R10: With the filter off, each rising edge of `ext_clk_i[c]` counts once, provided the pin stays high at least two clock cycles and low at least two.
- R11: With `nr_en_i[c]` = 1, a level on `ext_clk_i[c]` must persist for NR_CYC (default 16) clock cycles before it is seen. Shorter pulses are dropped.
- R12: With `cascade_i` = 0, the two channels count, reload and flag independently of each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Internal prescaled count enable |
| ext_clk_i | input | 2 | External count clock, one per channel |
| cascade_i | input | 1 | 1 joins the channels into one 16-bit counter |
| run_i | input | 2 | Per-channel run (1) / stop (0) |
| preset_i | input | 2 | Per-channel load pulse |
| src_ext_i | input | 2 | Per-channel source: 0 internal tick, 1 external pin |
| nr_en_i | input | 2 | Per-channel noise rejector enable |
| pwm_en_i | input | 2 | Per-channel waveform output enable |
| reload_i | input | 16 | Reload values, channel 0 in bits 7:0 |
| compare_i | input | 16 | Compare values, channel 0 in bits 7:0 |
| count_o | output | 16 | Counter readback, channel 0 in bits 7:0 |
| uf_o | output | 2 | One-cycle underflow pulses |
| pwm_o | output | 2 | Waveform outputs |

## Verification
The properties assume that the reload and compare values behind a preset or an underflow are the ones sampled one edge earlier. The stimulus meets this by changing reload and compare only while the counters are stopped. The properties also assume that `cascade_i` changes only between steps. The bench switches mode only while no channel runs, and it sets the filter enable only while the external pin is low. Each external pulse it drives is followed by a low gap longer than the filter window, so every expected count is reached before the bench reads it.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic {
    SRC_TICK = 1'b0,
    SRC_EXT  = 1'b1
  } src_e;

  localparam int NUM_CH = 2;
endpackage

// File: rtl/tmr_ext_edge.sv
module tmr_ext_edge #(
  parameter int NR_CYC = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic ext_i,
  input  logic nr_en_i,
  output logic rise_o
);
  localparam int NW = $clog2(NR_CYC + 1);
  localparam logic [NW-1:0] LAST = NW'(NR_CYC - 1);
  localparam logic [NW-1:0] ONE  = NW'(1);

  logic [1:0]    sync_q;
  logic          filt_q;
  logic [NW-1:0] run_q;
  logic          sel;
  logic          sel_q;
  logic          rise_q;

  // two-stage synchroniser for the asynchronous pin
  always_ff @(posedge clk) begin
    if (rst) sync_q <= 2'b00;
    else     sync_q <= {sync_q[0], ext_i};
  end

  // a new level is accepted only after NR_CYC consecutive mismatching cycles
  always_ff @(posedge clk) begin
    if (rst) begin
      filt_q <= 1'b0;
      run_q  <= '0;
    end else if (sync_q[1] != filt_q) begin
      if (run_q == LAST) begin
        filt_q <= sync_q[1];
        run_q  <= '0;
      end else begin
        run_q <= run_q + ONE;
      end
    end else begin
      run_q <= '0;
    end
  end

  assign sel = nr_en_i ? filt_q : sync_q[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q  <= 1'b0;
      rise_q <= 1'b0;
    end else begin
      sel_q  <= sel;
      rise_q <= sel & ~sel_q;
    end
  end

  assign rise_o = rise_q;
endmodule

// File: rtl/tmr_chan.sv
module tmr_chan #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          step_i,
  input  logic          load_i,
  input  logic          last_i,
  input  logic          flag_en_i,
  input  logic [CW-1:0] reload_i,
  output logic [CW-1:0] cnt_o,
  output logic          uf_o
);
  localparam logic [CW-1:0] ALL1 = '1;
  localparam logic [CW-1:0] ONE  = CW'(1);

  logic [CW-1:0] cnt_q;
  logic          uf_q;
  logic          at_zero;

  assign at_zero = (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= ALL1;
      uf_q  <= 1'b0;
    end else begin
      uf_q <= 1'b0;
      if (load_i) begin
        cnt_q <= reload_i;
      end else if (step_i) begin
        if (!at_zero) begin
          cnt_q <= cnt_q - ONE;
        end else if (last_i) begin
          cnt_q <= reload_i;
          uf_q  <= flag_en_i;
        end else begin
          cnt_q <= ALL1;   // borrow into the upper byte
        end
      end
    end
  end

  assign cnt_o = cnt_q;
  assign uf_o  = uf_q;
endmodule

// File: rtl/tmr_pwm.sv
module tmr_pwm #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en_i,
  input  logic [W-1:0] cnt_i,
  input  logic [W-1:0] cmp_i,
  output logic         pwm_o
);
  logic pwm_q;

  always_ff @(posedge clk) begin
    if (rst) pwm_q <= 1'b0;
    else     pwm_q <= en_i && (cnt_i <= cmp_i);
  end

  assign pwm_o = pwm_q;
endmodule

// File: rtl/pair_reload_timer.sv
module pair_reload_timer
  import tmr_pkg::*;
#(
  parameter int CW     = 8,
  parameter int NR_CYC = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            tick_i,
  input  logic [1:0]      ext_clk_i,
  input  logic            cascade_i,
  input  logic [1:0]      run_i,
  input  logic [1:0]      preset_i,
  input  logic [1:0]      src_ext_i,
  input  logic [1:0]      nr_en_i,
  input  logic [1:0]      pwm_en_i,
  input  logic [2*CW-1:0] reload_i,
  input  logic [2*CW-1:0] compare_i,
  output logic [2*CW-1:0] count_o,
  output logic [1:0]      uf_o,
  output logic [1:0]      pwm_o
);
  localparam int DW = 2 * CW;

  logic [1:0]    ext_rise;
  logic [1:0]    step_raw;
  logic [CW-1:0] lo_cnt;
  logic [CW-1:0] hi_cnt;
  logic          lo_step;
  logic          hi_step;
  logic          lo_last;
  logic          hi_load;
  logic          lo_uf;
  logic          hi_uf;
  logic          p1_en;
  logic [DW-1:0] p1_cnt;
  logic [DW-1:0] p1_cmp;

  // per-channel count source selection
  genvar g;
  generate
    for (g = 0; g < NUM_CH; g++) begin : g_src
      tmr_ext_edge #(.NR_CYC(NR_CYC)) u_edge (
        .clk     (clk),
        .rst     (rst),
        .ext_i   (ext_clk_i[g]),
        .nr_en_i (nr_en_i[g]),
        .rise_o  (ext_rise[g])
      );
      assign step_raw[g] = run_i[g] &&
        ((src_e'(src_ext_i[g]) == SRC_EXT) ? ext_rise[g] : tick_i);
    end
  endgenerate

  // chaining: in 16-bit mode the upper byte steps on the lower byte's borrow
  assign lo_step = step_raw[0];
  assign hi_step = cascade_i ? (lo_step && (lo_cnt == '0)) : step_raw[1];
  assign lo_last = !cascade_i || (hi_cnt == '0);
  assign hi_load = cascade_i ? preset_i[0] : preset_i[1];

  tmr_chan #(.CW(CW)) u_lo (
    .clk       (clk),
    .rst       (rst),
    .step_i    (lo_step),
    .load_i    (preset_i[0]),
    .last_i    (lo_last),
    .flag_en_i (!cascade_i),
    .reload_i  (reload_i[CW-1:0]),
    .cnt_o     (lo_cnt),
    .uf_o      (lo_uf)
  );

  tmr_chan #(.CW(CW)) u_hi (
    .clk       (clk),
    .rst       (rst),
    .step_i    (hi_step),
    .load_i    (hi_load),
    .last_i    (1'b1),
    .flag_en_i (1'b1),
    .reload_i  (reload_i[DW-1:CW]),
    .cnt_o     (hi_cnt),
    .uf_o      (hi_uf)
  );

  // waveform shaping: channel 1's comparator widens to 16 bits when chained
  tmr_pwm #(.W(CW)) u_pwm_lo (
    .clk   (clk),
    .rst   (rst),
    .en_i  (pwm_en_i[0] && !cascade_i),
    .cnt_i (lo_cnt),
    .cmp_i (compare_i[CW-1:0]),
    .pwm_o (pwm_o[0])
  );

  assign p1_en  = cascade_i ? pwm_en_i[0] : pwm_en_i[1];
  assign p1_cnt = cascade_i ? {hi_cnt, lo_cnt} : {{CW{1'b0}}, hi_cnt};
  assign p1_cmp = cascade_i ? compare_i : {{CW{1'b0}}, compare_i[DW-1:CW]};

  tmr_pwm #(.W(DW)) u_pwm_hi (
    .clk   (clk),
    .rst   (rst),
    .en_i  (p1_en),
    .cnt_i (p1_cnt),
    .cmp_i (p1_cmp),
    .pwm_o (pwm_o[1])
  );

  assign count_o = {hi_cnt, lo_cnt};
  assign uf_o    = {hi_uf, lo_uf};
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker #(
  parameter int CW = 8
) (
  input logic            clk,
  input logic            rst,
  input logic            cascade_i,
  input logic [1:0]      run_i,
  input logic [1:0]      preset_i,
  input logic [1:0]      pwm_en_i,
  input logic [2*CW-1:0] reload_i,
  input logic [2*CW-1:0] count_o,
  input logic [1:0]      uf_o,
  input logic [1:0]      pwm_o
);
  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (count_o == '1) && (uf_o == 2'b00) && (pwm_o == 2'b00));

  a_r2_preset_loads: assert property (@(posedge clk) disable iff (rst)
    (preset_i[0] && !cascade_i) |=> (count_o[CW-1:0] == $past(reload_i[CW-1:0])));

  a_r3_stopped_hold: assert property (@(posedge clk) disable iff (rst)
    ((run_i == 2'b00) && (preset_i == 2'b00)) |=> $stable(count_o));

  a_r5_uf_reloads: assert property (@(posedge clk) disable iff (rst)
    uf_o[0] |-> (count_o[CW-1:0] == $past(reload_i[CW-1:0])));

  a_r7_pwm_disabled: assert property (@(posedge clk) disable iff (rst)
    !pwm_en_i[0] |=> !pwm_o[0]);

  a_r9_cascade_low_quiet: assert property (@(posedge clk) disable iff (rst)
    cascade_i |=> (!uf_o[0] && !pwm_o[0]));

  a_r9_cascade_full_reload: assert property (@(posedge clk) disable iff (rst)
    (uf_o[1] && $past(cascade_i)) |-> (count_o == $past(reload_i)));
endmodule

bind pair_reload_timer tmr_checker #(.CW(CW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cascade_i (cascade_i),
  .run_i     (run_i),
  .preset_i  (preset_i),
  .pwm_en_i  (pwm_en_i),
  .reload_i  (reload_i),
  .count_o   (count_o),
  .uf_o      (uf_o),
  .pwm_o     (pwm_o)
);

// File: tb/pair_reload_timer_tb_top.sv
module pair_reload_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick_i = 1'b0;
  logic [1:0]  ext_clk_i = '0;
  logic        cascade_i = 1'b0;
  logic [1:0]  run_i = '0;
  logic [1:0]  preset_i = '0;
  logic [1:0]  src_ext_i = '0;
  logic [1:0]  nr_en_i = '0;
  logic [1:0]  pwm_en_i = '0;
  logic [15:0] reload_i = '0;
  logic [15:0] compare_i = '0;
  logic [15:0] count_o;
  logic [1:0]  uf_o;
  logic [1:0]  pwm_o;

  int n_checks = 0;
  int n_fails  = 0;
  int uf0_seen = 0;
  int uf1_seen = 0;
  bit done     = 1'b0;

  always #2 clk = ~clk;

  pair_reload_timer dut_i (
    .clk(clk), .rst(rst), .tick_i(tick_i), .ext_clk_i(ext_clk_i),
    .cascade_i(cascade_i), .run_i(run_i), .preset_i(preset_i),
    .src_ext_i(src_ext_i), .nr_en_i(nr_en_i), .pwm_en_i(pwm_en_i),
    .reload_i(reload_i), .compare_i(compare_i), .count_o(count_o),
    .uf_o(uf_o), .pwm_o(pwm_o)
  );

  typedef struct {
    int          sel;
    logic [31:0] exp;
    string       req;
  } exp_t;

  exp_t sb_q[$];

  always @(negedge clk) begin
    if (!rst) begin
      if (uf_o[0]) uf0_seen++;
      if (uf_o[1]) uf1_seen++;
    end
  end

  function automatic logic [31:0] observe(int sel);
    case (sel)
      0:       return {16'h0, count_o};
      1:       return {30'h0, pwm_o};
      2:       return uf0_seen;
      3:       return uf1_seen;
      default: return {30'h0, uf_o};
    endcase
  endfunction

  // monitor: pops expectations and compares against the ports
  initial begin
    forever begin
      wait (sb_q.size() > 0);
      begin
        exp_t it;
        logic [31:0] act;
        it  = sb_q.pop_front();
        act = observe(it.sel);
        n_checks++;
        if (act !== it.exp) begin
          n_fails++;
          $display("FAIL %s: sel %0d actual %0h expected %0h", it.req, it.sel, act, it.exp);
        end
      end
    end
  end

  task automatic expect_item(int sel, logic [31:0] exp, string req);
    exp_t it;
    it.sel = sel; it.exp = exp; it.req = req;
    sb_q.push_back(it);
    wait (sb_q.size() == 0);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ticks(int n);
    repeat (n) begin
      @(negedge clk) tick_i = 1'b1;
    end
    @(negedge clk) tick_i = 1'b0;
    idle(3);
  endtask

  task automatic pulse_preset(logic [1:0] m);
    @(negedge clk) preset_i = m;
    @(negedge clk) preset_i = 2'b00;
    idle(2);
  endtask

  task automatic ext_pulse(int ch, int hi_cyc, int lo_cyc);
    @(negedge clk) ext_clk_i[ch] = 1'b1;
    idle(hi_cyc);
    ext_clk_i[ch] = 1'b0;
    idle(lo_cyc);
  endtask

  initial begin
    idle(3);
    rst = 1'b0;
    idle(1);
    expect_item(0, 32'hFFFF, "R1 count after reset");
    expect_item(1, 32'h0,    "R1 pwm after reset");
    expect_item(4, 32'h0,    "R1 uf after reset");

    reload_i  = 16'h0305;
    compare_i = 16'h0102;
    pwm_en_i  = 2'b11;
    pulse_preset(2'b11);
    expect_item(0, 32'h0305, "R2 preset loads reload");
    expect_item(1, 32'h0,    "R6 above compare gives low");

    ticks(10);
    expect_item(0, 32'h0305, "R3 stopped channels hold");

    run_i = 2'b01;
    ticks(3);
    expect_item(0, 32'h0302, "R12 only channel 0 steps");
    expect_item(1, 32'h1,    "R6 count at compare gives high");

    ticks(3);
    expect_item(0, 32'h0305, "R5 zero step reloads");
    expect_item(2, 32'h1,    "R5 one underflow pulse");
    expect_item(1, 32'h0,    "R6 reload returns low");

    pwm_en_i = 2'b10;
    ticks(3);
    expect_item(0, 32'h0302, "R5 decrement");
    expect_item(1, 32'h0,    "R7 disabled output low");

    src_ext_i = 2'b01;
    ticks(4);
    expect_item(0, 32'h0302, "R4 tick ignored on external source");
    ext_pulse(0, 2, 6);
    ext_pulse(0, 2, 6);
    expect_item(0, 32'h0300, "R10 bypass counts each edge");

    run_i = 2'b11;
    ticks(4);
    expect_item(0, 32'h0300, "R12 channel 0 unaffected by tick");
    expect_item(3, 32'h1,    "R12 channel 1 underflow");
    expect_item(2, 32'h1,    "R12 channel 0 flag unchanged");

    nr_en_i = 2'b01;
    ext_pulse(0, 8, 30);
    expect_item(0, 32'h0300, "R11 short pulse rejected");
    ext_pulse(0, 20, 30);
    expect_item(0, 32'h0305, "R11 long pulse passes");
    expect_item(2, 32'h2,    "R11 reload flag after filtered edge");

    run_i     = 2'b00;
    src_ext_i = 2'b00;
    nr_en_i   = 2'b00;
    idle(2);
    cascade_i = 1'b1;
    reload_i  = 16'h0102;
    compare_i = 16'h0100;
    pwm_en_i  = 2'b01;
    pulse_preset(2'b01);
    expect_item(0, 32'h0102, "R8 chained preset");
    expect_item(1, 32'h0,    "R9 above 16-bit compare");
    run_i = 2'b01;
    ticks(3);
    expect_item(0, 32'h00FF, "R8 borrow wraps low byte");
    expect_item(1, 32'h2,    "R9 16-bit compare drives output 1");
    ticks(255);
    expect_item(0, 32'h0000, "R8 chained count to zero");
    expect_item(3, 32'h1,    "R9 no flag before full underflow");
    ticks(1);
    expect_item(0, 32'h0102, "R9 full underflow reloads both");
    expect_item(3, 32'h2,    "R9 high flag on full underflow");
    expect_item(2, 32'h2,    "R9 low flag quiet when chained");

    run_i    = 2'b00;
    reload_i = 16'h0A0A;
    pulse_preset(2'b10);
    expect_item(0, 32'h0102, "R8 channel 1 preset ignored when chained");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end
endmodule